// File: doc/BRIEF.md
# Serial FPGA configuration sequencer

This block loads a target FPGA over a slave-serial link, entirely in hardware. A start pulse begins the sequence. The block drives the active-low program line low and waits for the target to pull its init status pin low. It then releases the program line and waits for the init pin to return high. Next it confirms that the target's done pin is still low and waits a fixed programming latency. After that it accepts configuration bytes on a valid/ready stream. Each accepted byte goes out most significant bit first on a serial clock and data pair. The serial clock is divided down from the system clock by a run-time divisor.

When the byte marked last has been shifted out, the block keeps sending all-ones pad bytes. It samples DONE at the start of each pad byte. It ends with success after the pad byte during which DONE was seen high. It ends with an error once a run-time completion timeout has elapsed with DONE still low. On such a timeout the level of the init pin tells the two failure causes apart: a checksum failure or wrong device, or a stream that lacked its sync word or stopped short. A strap input declares the init pin absent. In that case the block replaces the first init wait with a fixed minimum pulse, skips the second wait, and reports a plain timeout at the end. Every millisecond and microsecond delay is derived from a clock-frequency parameter.

Top module: `fpga_cfg_seq`

## Requirements
- R1: A start while idle with `partial_i` high is refused. `err_o` becomes 1, `busy_o` stays low, and the program line and serial clock are not touched.
- R2: An accepted start drives `prog_b_o` low and holds it low until the synchronised `init_b_i` reads low. It then drives `prog_b_o` high again.
- R3: With `init_absent_i` high, `init_b_i` is ignored. `prog_b_o` is held low for at least PROG_NS nanoseconds, rounded up to whole clocks, and for no more than a few clocks beyond that.
- R4: Each wait on the init pin, first for low and then for high, ends after INIT_WAIT_US microseconds. On expiry `err_o` becomes 2 and `prog_b_o` is high.
- R5: If DONE reads high once the init pin has returned high, the sequence stops with `err_o` = 3 and no data is accepted.
- R6: `s_ready_o` does not rise until at least LAT_US microseconds after the init pin is seen high again.
- R7: Bytes are shifted out most significant bit first. `dout_o` changes only while `cclk_o` is low, and `cclk_o` is low when idle. Each half period of `cclk_o` lasts `clk_div_i`+1 clock cycles.
- R8: After the last byte, 0xFF pad bytes are sent and DONE is sampled at the start of each one. The block sets `ok_o` (with `err_o` = 0) after finishing the pad byte at whose start DONE read high, so at least one pad byte is always sent.
- R9: A pad byte that starts with DONE low and with at least `cpl_tmo_i` cycles elapsed since padding began is the final one. After it, `err_o` becomes 4 if the init pin is low, 5 if it is high, or 6 if the pin is absent. This DONE check and this pad byte happen even when `cpl_tmo_i` is 0.
- R10: After reset `prog_b_o` is high and `busy_o`, `ok_o` and `err_o` are 0. `busy_o` is high from an accepted start until the result is posted. `ok_o` and `err_o` are cleared by an accepted start and otherwise hold, whatever the status pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| partial_i | input | 1 | Start asks for partial reconfiguration (refused) |
| init_absent_i | input | 1 | Strap: the init status pin is not wired |
| init_b_i | input | 1 | Target init status pin, low means asserted |
| done_i | input | 1 | Target done status pin |
| clk_div_i | input | DIV_W | Serial clock half period minus one, in clock cycles |
| cpl_tmo_i | input | TMR_W | Completion timeout in clock cycles |
| s_valid_i | input | 1 | Configuration byte valid |
| s_data_i | input | 8 | Configuration byte |
| s_last_i | input | 1 | Marks the final configuration byte |
| s_ready_o | output | 1 | Block takes the byte on this cycle |
| prog_b_o | output | 1 | Program line to the target, active low |
| cclk_o | output | 1 | Serial configuration clock |
| dout_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Last sequence finished successfully |
| err_o | output | 3 | Last sequence's error code, 0 for none |

## Verification
A sequencer stuck in the wrong phase shows up at the pins within one wait window. The program line stays low too long or too short. `s_ready_o` rises before the latency ends. Or `busy_o` never falls, so the final code is wrong by the time the timeout window ends. A fault in the shifter or its divider shows up on the very first byte: the received bytes come out reordered or wrong, and the count of high serial-clock cycles no longer matches the byte count. A fault in the pad loop, such as checking DONE after the timeout or skipping the final pad, changes the number of 0xFF bytes the bench receives or the error code posted once `busy_o` falls.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_REL,
        ST_CHK,
        ST_LAT,
        ST_STREAM,
        ST_DRAIN,
        ST_PAD_GO,
        ST_PAD_WAIT
    } seq_st_e;

    localparam logic [2:0] ERR_NONE       = 3'd0;
    localparam logic [2:0] ERR_BADREQ     = 3'd1;
    localparam logic [2:0] ERR_INIT_TMO   = 3'd2;
    localparam logic [2:0] ERR_DONE_EARLY = 3'd3;
    localparam logic [2:0] ERR_CRC        = 3'd4;
    localparam logic [2:0] ERR_NOSYNC     = 3'd5;
    localparam logic [2:0] ERR_CPL_TMO    = 3'd6;

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
    parameter int              WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_d, meta_q;
    logic [WIDTH-1:0] stab_d, stab_q;

    always_comb begin
        meta_d = d_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [7:0]       byte_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             busy_o,
    output logic             cclk_o,
    output logic             dout_o
);
    typedef struct packed {
        logic             busy;
        logic             cclk;
        logic [7:0]       sh;
        logic [2:0]       bitn;
        logic [DIV_W-1:0] divc;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!sh_q.busy) begin
            if (load_i) begin
                sh_d.busy = 1'b1;
                sh_d.sh   = byte_i;
                sh_d.bitn = '0;
                sh_d.divc = '0;
                sh_d.cclk = 1'b0;
            end
        end else if (sh_q.divc == div_i) begin
            sh_d.divc = '0;
            if (!sh_q.cclk) begin
                sh_d.cclk = 1'b1;
            end else begin
                sh_d.cclk = 1'b0;
                if (sh_q.bitn == 3'd7) begin
                    sh_d.busy = 1'b0;
                end else begin
                    sh_d.bitn = sh_q.bitn + 3'd1;
                    sh_d.sh   = {sh_q.sh[6:0], 1'b0};
                end
            end
        end else begin
            sh_d.divc = sh_q.divc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign busy_o = sh_q.busy;
    assign cclk_o = sh_q.cclk;
    assign dout_o = sh_q.sh[7];

    // R7: data moves only while the serial clock is low
    p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_o) |-> !cclk_o);

    // R7: serial clock rests low between bytes
    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_i) |=> !cclk_o);
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int PROG_NS     = 500,
    parameter int INIT_WAIT_US = 1000000,
    parameter int LAT_US      = 7500,
    parameter int DIV_W       = 4,
    parameter int TMR_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             partial_i,
    input  logic             init_absent_i,
    input  logic             init_b_i,
    input  logic             done_i,
    input  logic [DIV_W-1:0] clk_div_i,
    input  logic [TMR_W-1:0] cpl_tmo_i,
    input  logic             s_valid_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_last_i,
    output logic             s_ready_o,
    output logic             prog_b_o,
    output logic             cclk_o,
    output logic             dout_o,
    output logic             busy_o,
    output logic             ok_o,
    output logic [2:0]       err_o
);
    localparam longint unsigned PROG_L = (longint'(CLK_MHZ) * PROG_NS + 999) / 1000;
    localparam longint unsigned INIT_L = longint'(CLK_MHZ) * INIT_WAIT_US;
    localparam longint unsigned LAT_L  = longint'(CLK_MHZ) * LAT_US;
    localparam logic [TMR_W-1:0] PROG_CYC = PROG_L[TMR_W-1:0];
    localparam logic [TMR_W-1:0] INIT_CYC = INIT_L[TMR_W-1:0];
    localparam logic [TMR_W-1:0] LAT_CYC  = LAT_L[TMR_W-1:0];

    typedef struct packed {
        seq_st_e          st;
        logic             prog_b;
        logic [TMR_W-1:0] tmr;
        logic             pad_done;
        logic             pad_exp;
        logic             ok;
        logic [2:0]       err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic       init_s, done_s;
    logic       sh_busy, sh_load;
    logic [7:0] sh_byte;
    logic [TMR_W-1:0] tmr_inc;

    cfg_sync2 #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({init_b_i, done_i}),
        .q_o  ({init_s, done_s})
    );

    cfg_shift #(.DIV_W(DIV_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(sh_load),
        .byte_i(sh_byte),
        .div_i (clk_div_i),
        .busy_o(sh_busy),
        .cclk_o(cclk_o),
        .dout_o(dout_o)
    );

    assign tmr_inc   = (ctl_q.tmr == '1) ? ctl_q.tmr : ctl_q.tmr + 1'b1;
    assign s_ready_o = (ctl_q.st == ST_STREAM) && !sh_busy;

    always_comb begin
        ctl_d   = ctl_q;
        sh_load = 1'b0;
        sh_byte = 8'hFF;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.ok = 1'b0;
                    if (partial_i) begin
                        ctl_d.err = ERR_BADREQ;
                    end else begin
                        ctl_d.err    = ERR_NONE;
                        ctl_d.prog_b = 1'b0;
                        ctl_d.tmr    = '0;
                        ctl_d.st     = ST_PROG;
                    end
                end
            end
            ST_PROG: begin
                ctl_d.tmr = tmr_inc;
                if (init_absent_i ? (ctl_q.tmr == PROG_CYC) : !init_s) begin
                    ctl_d.prog_b = 1'b1;
                    ctl_d.tmr    = '0;
                    ctl_d.st     = ST_REL;
                end else if (!init_absent_i && ctl_q.tmr == INIT_CYC) begin
                    ctl_d.prog_b = 1'b1;
                    ctl_d.err    = ERR_INIT_TMO;
                    ctl_d.st     = ST_IDLE;
                end
            end
            ST_REL: begin
                ctl_d.tmr = tmr_inc;
                if (init_absent_i || init_s) begin
                    ctl_d.st = ST_CHK;
                end else if (ctl_q.tmr == INIT_CYC) begin
                    ctl_d.err = ERR_INIT_TMO;
                    ctl_d.st  = ST_IDLE;
                end
            end
            ST_CHK: begin
                if (done_s) begin
                    ctl_d.err = ERR_DONE_EARLY;
                    ctl_d.st  = ST_IDLE;
                end else begin
                    ctl_d.tmr = '0;
                    ctl_d.st  = ST_LAT;
                end
            end
            ST_LAT: begin
                ctl_d.tmr = tmr_inc;
                if (ctl_q.tmr == LAT_CYC) ctl_d.st = ST_STREAM;
            end
            ST_STREAM: begin
                if (s_valid_i && !sh_busy) begin
                    sh_load = 1'b1;
                    sh_byte = s_data_i;
                    if (s_last_i) ctl_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!sh_busy) begin
                    ctl_d.tmr = '0;
                    ctl_d.st  = ST_PAD_GO;
                end
            end
            ST_PAD_GO: begin
                ctl_d.tmr      = tmr_inc;
                ctl_d.pad_done = done_s;
                ctl_d.pad_exp  = (ctl_q.tmr >= cpl_tmo_i);
                sh_load        = 1'b1;
                ctl_d.st       = ST_PAD_WAIT;
            end
            ST_PAD_WAIT: begin
                ctl_d.tmr = tmr_inc;
                if (!sh_busy) begin
                    if (ctl_q.pad_done) begin
                        ctl_d.ok = 1'b1;
                        ctl_d.st = ST_IDLE;
                    end else if (ctl_q.pad_exp) begin
                        ctl_d.err = init_absent_i ? ERR_CPL_TMO :
                                    (init_s ? ERR_NOSYNC : ERR_CRC);
                        ctl_d.st  = ST_IDLE;
                    end else begin
                        ctl_d.st = ST_PAD_GO;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= ST_IDLE;
            ctl_q.prog_b   <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign prog_b_o = ctl_q.prog_b;
    assign busy_o   = (ctl_q.st != ST_IDLE);
    assign ok_o     = ctl_q.ok;
    assign err_o    = ctl_q.err;

    // R1: a partial request is refused without starting
    p_badreq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && partial_i) |=> (err_o == ERR_BADREQ && prog_b_o && !busy_o));

    // R2: the program line is only low inside a sequence
    p_prog_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_b_o |-> busy_o);

    // R4: an init timeout leaves the program line released
    p_init_tmo_rel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && err_o == ERR_INIT_TMO) |-> prog_b_o);

    // R8: success is only posted from the end of a pad byte
    p_ok_after_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> ($past(ctl_q.st) == ST_PAD_WAIT));

    // R10: success and error never coexist
    p_ok_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (err_o == ERR_NONE));

    // R10: status holds while idle and no start arrives
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(ok_o) && $stable(err_o)));
endmodule

// File: tb/fpga_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module fpga_cfg_seq_tb_top;
    localparam int CLK_MHZ  = 200;
    localparam int PROG_NS  = 500;
    localparam int INIT_US  = 20;
    localparam int LAT_US   = 1;
    localparam int PROG_EXP = (CLK_MHZ * PROG_NS + 999) / 1000;
    localparam int INIT_EXP = CLK_MHZ * INIT_US;
    localparam int LAT_EXP  = CLK_MHZ * LAT_US;
    localparam int NV       = 12;

    typedef struct packed {
        logic       partial;
        logic       absent;
        logic [1:0] imode;
        logic       early;
        logic [3:0] nbytes;
        logic [1:0] div;
        logic [3:0] done_at;
        logic       crc_end;
        logic [7:0] tmo;
        logic [2:0] exp_err;
        logic       exp_ok;
        logic [3:0] exp_pads;
    } vec_t;

    function automatic vec_t mk(int p, int a, int im, int e, int nb, int dv, int da,
                                int ce, int tm, int ee, int eo, int ep);
        vec_t v;
        v.partial = p[0];   v.absent = a[0];   v.imode = im[1:0]; v.early = e[0];
        v.nbytes  = nb[3:0]; v.div = dv[1:0];  v.done_at = da[3:0];
        v.crc_end = ce[0];  v.tmo = tm[7:0];   v.exp_err = ee[2:0];
        v.exp_ok  = eo[0];  v.exp_pads = ep[3:0];
        return v;
    endfunction

    // partial absent imode early nbytes div done_at crc tmo err ok pads
    localparam vec_t VECS [NV] = '{
        mk(0, 0, 0, 0, 3, 1,  2, 0, 255, 0, 1, 3),
        mk(0, 0, 0, 0, 5, 0,  0, 0, 255, 0, 1, 1),
        mk(0, 1, 0, 0, 2, 2,  1, 0, 255, 0, 1, 2),
        mk(1, 0, 0, 0, 0, 1, 15, 0, 255, 1, 0, 0),
        mk(0, 0, 1, 0, 0, 1, 15, 0, 255, 2, 0, 0),
        mk(0, 0, 2, 0, 0, 1, 15, 0, 255, 2, 0, 0),
        mk(0, 0, 0, 1, 0, 1, 15, 0, 255, 3, 0, 0),
        mk(0, 0, 0, 0, 2, 1, 15, 1,   0, 4, 0, 1),
        mk(0, 0, 0, 0, 2, 1, 15, 0,   0, 5, 0, 1),
        mk(0, 1, 0, 0, 2, 1, 15, 0,   0, 6, 0, 1),
        mk(0, 0, 0, 0, 1, 3,  3, 0, 255, 0, 1, 4),
        mk(0, 0, 0, 0, 1, 0,  0, 0,   0, 0, 1, 1)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, partial = 1'b0, absent = 1'b0;
    logic        init_b, done;
    logic [3:0]  clk_div = 4'd1;
    logic [31:0] cpl_tmo = 32'd0;
    logic        s_valid = 1'b0, s_last = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        s_ready, prog_b, cclk, dout, busy, ok;
    logic [2:0]  err;

    int   n_chk = 0, n_fail = 0;
    bit   fin = 1'b0;

    logic       cur_early = 1'b0, cur_crc = 1'b0;
    logic [1:0] cur_imode = 2'd0;
    int         cur_nb = 0, cur_da = 15;
    int         rx_n = 0, rx_base = 0;
    logic [7:0] rx_buf [64];
    logic [7:0] rx_sh = 8'h00;
    int         rx_bits = 0;
    logic [2:0] pdly = 3'b111;
    logic       stuck = 1'b0;
    logic       meas_clr = 1'b0;
    int         prog_lo = 0, cclk_hi = 0, lat_cnt = 0;
    logic       seen_rdy = 1'b0;

    always #2.5 clk = ~clk;

    fpga_cfg_seq #(
        .CLK_MHZ(CLK_MHZ), .PROG_NS(PROG_NS), .INIT_WAIT_US(INIT_US),
        .LAT_US(LAT_US), .DIV_W(4), .TMR_W(32)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .partial_i(partial),
        .init_absent_i(absent), .init_b_i(init_b), .done_i(done),
        .clk_div_i(clk_div), .cpl_tmo_i(cpl_tmo), .s_valid_i(s_valid),
        .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
        .prog_b_o(prog_b), .cclk_o(cclk), .dout_o(dout), .busy_o(busy),
        .ok_o(ok), .err_o(err)
    );

    // target model: init follows the program line three cycles late
    always @(posedge clk) begin
        pdly <= {pdly[1:0], prog_b};
        if (cur_imode != 2'd2) stuck <= 1'b0;
        else if (!pdly[2])     stuck <= 1'b1;
    end

    assign init_b = (cur_imode == 2'd1) ? 1'b1 :
                    ((stuck || (cur_crc && (rx_n - rx_base) >= cur_nb)) ? 1'b0 : pdly[2]);
    assign done   = cur_early || (cur_da != 15 && (rx_n - rx_base) >= (cur_nb + cur_da));

    // serial receiver: the target samples on the rising serial clock
    always @(posedge cclk) begin
        rx_sh = {rx_sh[6:0], dout};
        rx_bits++;
        if (rx_bits == 8) begin
            rx_buf[rx_n % 64] = rx_sh;
            rx_n++;
            rx_bits = 0;
        end
    end

    // pin measurements, taken 1 ns after each rising clock edge
    always @(posedge clk) begin
        #1;
        if (meas_clr) begin
            prog_lo = 0; cclk_hi = 0; lat_cnt = 0; seen_rdy = 1'b0;
        end else begin
            if (!prog_b) prog_lo++;
            if (cclk)    cclk_hi++;
            if (s_ready) seen_rdy = 1'b1;
            if (busy && prog_b && init_b && !s_ready && !seen_rdy) lat_cnt++;
        end
    end

    function automatic logic [7:0] dbyte(int v, int i);
        int x = 8'h3C + v * 17 + i * 53;
        return x[7:0] ^ 8'hA5;
    endfunction

    function automatic string err_req(logic [2:0] e);
        case (e)
            3'd0: return "R8";
            3'd1: return "R1";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(bit cond, string req, string what, int act, int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_bytes(int v, int nb);
        for (int i = 0; i < nb; i++) begin
            s_valid = 1'b1;
            s_data  = dbyte(v, i);
            s_last  = (i == nb - 1);
            for (int w = 0; w < 20000 && !s_ready; w++) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(prog_b == 1'b1, "R10", "reset prog_b", int'(prog_b), 1);
        chk(busy == 1'b0 && ok == 1'b0, "R10", "reset busy/ok", int'({busy, ok}), 0);
        chk(err == 3'd0, "R10", "reset err", int'(err), 0);
        chk(!s_ready && !cclk, "R7", "reset ready/cclk", int'({s_ready, cclk}), 0);

        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            int pads_rx;
            bit data_ok, pad_ok;
            cur_early = t.early;  cur_crc = t.crc_end;  cur_imode = t.imode;
            cur_nb    = int'(t.nbytes);
            cur_da    = int'(t.done_at);
            rx_base   = rx_n;
            partial   = t.partial; absent = t.absent;
            clk_div   = {2'b00, t.div};
            cpl_tmo   = {24'd0, t.tmo};
            meas_clr  = 1'b1;
            @(negedge clk);
            meas_clr  = 1'b0;
            start     = 1'b1;
            @(negedge clk);
            start     = 1'b0;
            if (t.nbytes != 0) send_bytes(v, int'(t.nbytes));
            for (int w = 0; w < 20000 && busy; w++) @(negedge clk);

            chk(err == t.exp_err, err_req(t.exp_err), $sformatf("vec %0d err_o", v),
                int'(err), int'(t.exp_err));
            chk(ok == t.exp_ok, err_req(t.exp_err), $sformatf("vec %0d ok_o", v),
                int'(ok), int'(t.exp_ok));
            chk(!busy && prog_b, "R10", $sformatf("vec %0d idle busy/prog_b", v),
                int'({busy, prog_b}), 1);
            chk((rx_n - rx_base) == int'(t.nbytes) + int'(t.exp_pads), "R8",
                $sformatf("vec %0d bytes received", v),
                rx_n - rx_base, int'(t.nbytes) + int'(t.exp_pads));
            data_ok = 1'b1;
            for (int i = 0; i < int'(t.nbytes); i++)
                if (rx_buf[(rx_base + i) % 64] !== dbyte(v, i)) data_ok = 1'b0;
            chk(data_ok, "R7", $sformatf("vec %0d serial data msb first", v),
                int'(data_ok), 1);
            pad_ok  = 1'b1;
            pads_rx = rx_n - rx_base - int'(t.nbytes);
            for (int i = 0; i < pads_rx; i++)
                if (rx_buf[(rx_base + int'(t.nbytes) + i) % 64] !== 8'hFF) pad_ok = 1'b0;
            chk(pad_ok, "R8", $sformatf("vec %0d pad value", v), int'(pad_ok), 1);
            chk(cclk_hi == (int'(t.nbytes) + int'(t.exp_pads)) * 8 * (int'(t.div) + 1), "R7",
                $sformatf("vec %0d serial clock high cycles", v), cclk_hi,
                (int'(t.nbytes) + int'(t.exp_pads)) * 8 * (int'(t.div) + 1));
            if (t.partial)
                chk(prog_lo == 0 && cclk_hi == 0, "R1", "partial: pins untouched", prog_lo, 0);
            else if (t.absent)
                chk(prog_lo >= PROG_EXP && prog_lo <= PROG_EXP + 4, "R3",
                    "absent init: program pulse", prog_lo, PROG_EXP);
            else if (t.imode == 2'd1)
                chk(prog_lo >= INIT_EXP && prog_lo <= INIT_EXP + 4, "R4",
                    "init never low: program pulse", prog_lo, INIT_EXP);
            else
                chk(prog_lo >= 3 && prog_lo <= 10, "R2",
                    $sformatf("vec %0d program pulse follows init", v), prog_lo, 6);
            if (t.nbytes != 0)
                chk(lat_cnt >= LAT_EXP && lat_cnt <= LAT_EXP + 10, "R6",
                    $sformatf("vec %0d latency before ready", v), lat_cnt, LAT_EXP);
            repeat (10) @(negedge clk);
        end

        // R10: status holds through status-pin activity while idle
        cur_early = 1'b1;
        cur_imode = 2'd2;
        repeat (40) @(negedge clk);
        chk(ok == 1'b1 && err == 3'd0 && !busy, "R10", "status held while idle",
            int'({ok, err}), 8);
        cur_early = 1'b0;
        cur_imode = 2'd0;

        // R1: refused request clears a previous success but touches no pin
        rx_base  = rx_n;
        meas_clr = 1'b1;
        partial  = 1'b1;
        @(negedge clk);
        meas_clr = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        repeat (5) @(negedge clk);
        chk(err == 3'd1 && ok == 1'b0, "R1", "refused after success", int'(err), 1);
        chk(prog_lo == 0 && !busy && (rx_n == rx_base), "R1", "refusal leaves pins idle",
            prog_lo, 0);

        fin = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule